// File: doc/BRIEF.md
# Two-Target Vectored Priority Interrupt Controller

This block gathers up to 29 level-sensitive interrupt sources and steers each one to one of two processor targets: a normal interrupt (target 0) and a fast interrupt (target 1). Software sets up each source through its own request register. That register holds a 4-bit priority, a target select, an enable and a software-request bit. Each target has a priority threshold. A source takes part in arbitration for a target only when its priority is strictly above that target's threshold. Because software can rewrite the threshold, a service routine can raise it to allow nesting only by more urgent sources.

For each target, a vector register joins a table base address held by software with the number of the source that currently wins for that target. A handler reads the vector and gets a ready-made pointer into its own dispatch table. A pending register shows the raw request state of every source. A constant features word reports how the block is sized. All registers sit on a simple word-addressed bus. A write is taken on the clock edge while `bus_we` is high, and read data is a combinational function of `bus_word`. Byte offsets below are four times the word address.

Top module: `pic_top`

## Requirements
- R1: After synchronous reset, every request register, both threshold registers and both vector base fields read 0, and `irq_norm` and `irq_fast` are 0.
- R2: The pending register (byte offset 0x200) has bit n set for source n (1..29) exactly when input `irq_src[n]` is high or the software-request bit of source n is set. Bits 0, 30 and 31 always read 0.
- R3: The features register (byte offset 0x300) reads 0x0002101D. Bits 7:0 give the source count (29), bits 15:8 give the priority-level count (16), and bits 21:16 give the target count (2).
- R4: The request register of source n sits at byte offset 0x400+4n. It reads back priority in bits 3:0, target select in bit 8 (1 = fast), enable in bit 16 and software request in bit 17. Bit 31 reads the raw pending state of source n and ignores writes. All other bits read 0.
- R5: A source is eligible for a target only when all of the following hold: it is enabled, it is pending, its target bit selects that target, and its priority is strictly greater than that target's threshold. A source with priority 0 is therefore never eligible.
- R6: The threshold registers (byte offsets 0x000 for normal, 0x004 for fast) store only bits 3:0, and the other bits read 0. A threshold of 15 blocks every source from its target.
- R7: Among the eligible sources of one target, the one with the highest priority wins. When several share that priority, the one with the lowest source number wins.
- R8: The vector registers (byte offsets 0x100 normal, 0x104 fast) store bits 31:11 as written. Bits 7:3 read the current winner number of that target, or 0 when no source is eligible. Bits 10:8 and 2:0 read 0.
- R9: Each interrupt output is registered. It is high in the cycle after a cycle in which its target had at least one eligible source.
- R10: A source mapped to one target has no effect on the other target's vector or interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_word | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| irq_src | input | 29 | Level interrupt inputs, bit n is source n (1..29) |
| irq_norm | output | 1 | Normal interrupt request, active high |
| irq_fast | output | 1 | Fast interrupt request, active high |

## Verification
The hardest situation to reach from the ports is a tie for top priority among several eligible sources while other sources, at higher priority, are filtered out by the threshold, the target select or the enable. A single directed case seldom builds this. The bench therefore gives all 29 sources a priority pattern derived from their number and a mixed target assignment. It then drives pseudo-random source masks from an LFSR while it sweeps both thresholds through all 16 values, so that the filtering and the tie-breaking interact in many combinations. A separate sweep gives every source the same priority, so that only the lowest-number rule decides the winner.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC  = 29;
    localparam int PRIO_W   = 4;
    localparam int NUM_LVL  = 1 << PRIO_W;
    localparam int NUM_TGT  = 2;
    localparam int IDX_W    = 5;
    localparam int BASE_LSB = 11;
    localparam int BASE_W   = 32 - BASE_LSB;
    localparam int IDX_LSB  = 3;

    localparam int F_TGT    = 8;
    localparam int F_EN     = 16;
    localparam int F_SW     = 17;
    localparam int F_PEND   = 31;

    localparam logic [9:0] W_MASK0 = 10'h000;
    localparam logic [9:0] W_MASK1 = 10'h001;
    localparam logic [9:0] W_VEC0  = 10'h040;
    localparam logic [9:0] W_VEC1  = 10'h041;
    localparam logic [9:0] W_PEND  = 10'h080;
    localparam logic [9:0] W_FEAT  = 10'h0C0;
    localparam logic [9:0] W_REQ   = 10'h100;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        prio_t prio;
        logic  tgt;
        logic  en;
        logic  swreq;
    } src_cfg_t;

    function automatic logic [31:0] req_word(src_cfg_t c, logic pend);
        logic [31:0] r;
        r = '0;
        r[PRIO_W-1:0] = c.prio;
        r[F_TGT]      = c.tgt;
        r[F_EN]       = c.en;
        r[F_SW]       = c.swreq;
        r[F_PEND]     = pend;
        return r;
    endfunction

    function automatic logic [31:0] feat_word(int nsrc, int nlvl, int ntgt);
        logic [31:0] r;
        r = '0;
        r[7:0]   = 8'(nsrc);
        r[15:8]  = 8'(nlvl);
        r[21:16] = 6'(ntgt);
        return r;
    endfunction

    function automatic logic [31:0] vec_word(logic [BASE_W-1:0] base, idx_t idx);
        logic [31:0] r;
        r = '0;
        r[31:BASE_LSB]              = base;
        r[IDX_LSB+IDX_W-1:IDX_LSB]  = idx;
        return r;
    endfunction
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  src_cfg_t wr_cfg,
    input  logic [N_SRC:1] irq_src,
    output src_cfg_t cfg      [N_SRC:1],
    output logic [N_SRC:1] raw_pend
);
    for (genvar n = 1; n <= N_SRC; n++) begin : g_src
        src_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q <= '0;
            else if (wr_en && wr_idx == idx_t'(n))
                cfg_q <= wr_cfg;
        end
        assign cfg[n]      = cfg_q;
        assign raw_pend[n] = irq_src[n] | cfg_q.swreq;
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int TGT   = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  src_cfg_t cfg      [N_SRC:1],
    input  logic [N_SRC:1] raw_pend,
    input  prio_t    mask,
    output idx_t     win_idx,
    output prio_t    win_prio,
    output logic     win_valid
);
    logic [N_SRC:0] elig;

    always_comb begin
        elig = '0;
        for (int n = 1; n <= N_SRC; n++)
            elig[n] = cfg[n].en && raw_pend[n] &&
                      (cfg[n].tgt == 1'(TGT)) && (cfg[n].prio > mask);
    end

    always_comb begin
        win_idx   = '0;
        win_prio  = '0;
        win_valid = 1'b0;
        for (int n = 1; n <= N_SRC; n++) begin
            if (elig[n] && cfg[n].prio > win_prio) begin
                win_idx   = idx_t'(n);
                win_prio  = cfg[n].prio;
                win_valid = 1'b1;
            end
        end
    end

    AST_WIN_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (cfg[win_idx].prio > mask));  // R5
    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (raw_pend[win_idx] && cfg[win_idx].en));  // R5
    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (win_idx == '0));  // R8
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [9:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_SRC:1]    irq_src,
    output logic              irq_norm,
    output logic              irq_fast
);
    localparam logic [31:0] FEATURES = feat_word(N_SRC, NUM_LVL, NUM_TGT);

    src_cfg_t              cfg      [N_SRC:1];
    logic [N_SRC:1]        raw_pend;
    prio_t                 mask_q   [NUM_TGT];
    logic [BASE_W-1:0]     base_q   [NUM_TGT];
    idx_t                  win_idx  [NUM_TGT];
    prio_t                 win_prio [NUM_TGT];
    logic [NUM_TGT-1:0]    win_valid;
    logic [NUM_TGT-1:0]    irq_q;

    logic [9:0] req_off;
    logic       req_hit;
    idx_t       req_idx;
    src_cfg_t   wr_cfg;
    logic       unused_wbits;

    assign req_off = bus_word - W_REQ;
    assign req_hit = (bus_word > W_REQ) && (req_off <= 10'(N_SRC));
    assign req_idx = req_hit ? idx_t'(req_off) : '0;

    assign wr_cfg.prio  = bus_wdata[PRIO_W-1:0];
    assign wr_cfg.tgt   = bus_wdata[F_TGT];
    assign wr_cfg.en    = bus_wdata[F_EN];
    assign wr_cfg.swreq = bus_wdata[F_SW];
    assign unused_wbits = ^{bus_wdata[10:9], bus_wdata[7:4], bus_wdata[31:18], bus_wdata[15:11]};

    pic_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we && req_hit),
        .wr_idx   (req_idx),
        .wr_cfg   (wr_cfg),
        .irq_src  (irq_src),
        .cfg      (cfg),
        .raw_pend (raw_pend)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[t] <= '0;
                base_q[t] <= '0;
                irq_q[t]  <= 1'b0;
            end else begin
                if (bus_we && bus_word == W_MASK0 + 10'(t))
                    mask_q[t] <= bus_wdata[PRIO_W-1:0];
                if (bus_we && bus_word == W_VEC0 + 10'(t))
                    base_q[t] <= bus_wdata[31:BASE_LSB];
                irq_q[t] <= win_valid[t];
            end
        end

        pic_arbiter #(.N_SRC(N_SRC), .TGT(t)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg),
            .raw_pend  (raw_pend),
            .mask      (mask_q[t]),
            .win_idx   (win_idx[t]),
            .win_prio  (win_prio[t]),
            .win_valid (win_valid[t])
        );
    end

    assign irq_norm = irq_q[0];
    assign irq_fast = irq_q[1];

    always_comb begin
        bus_rdata = '0;
        if (req_hit) begin
            bus_rdata = req_word(cfg[req_idx], raw_pend[req_idx]);
        end else begin
            case (bus_word)
                W_MASK0: bus_rdata = 32'(mask_q[0]);
                W_MASK1: bus_rdata = 32'(mask_q[1]);
                W_VEC0:  bus_rdata = vec_word(base_q[0], win_idx[0]);
                W_VEC1:  bus_rdata = vec_word(base_q[1], win_idx[1]);
                W_PEND:  bus_rdata = 32'({raw_pend, 1'b0});
                W_FEAT:  bus_rdata = FEATURES;
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_norm) |-> $past(win_valid[0]));  // R9
    AST_MASK_STORES_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_word == W_MASK0) |=> (mask_q[0] == $past(bus_wdata[PRIO_W-1:0])));  // R6
    AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mask_q[1] == 4'hF) |=> !irq_fast);  // R6
    AST_WIN_PRIO_CEIL: assert property (@(posedge clk) disable iff (rst)
        win_valid[0] |-> (win_prio[0] > mask_q[0]));  // R7
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
    localparam int NS = 29;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS:1] irq_src = '0;
    logic        irq_norm, irq_fast;

    pic_top dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          m_prio [1:NS];
    bit          m_tgt  [1:NS];
    bit          m_en   [1:NS];
    bit          m_sw   [1:NS];
    int          m_mask [0:1];
    logic [20:0] m_base [0:1];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [9:0] w, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [9:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w;
        #1 d = bus_rdata;
    endtask

    task automatic set_req(int n, int p, bit t, bit e, bit s);
        logic [31:0] d;
        d = 32'(p & 15) | (32'(t) << 8) | (32'(e) << 16) | (32'(s) << 17);
        m_prio[n] = p & 15; m_tgt[n] = t; m_en[n] = e; m_sw[n] = s;
        wr(10'h100 + 10'(n), d);
    endtask

    task automatic set_mask(int t, int v);
        m_mask[t] = v & 15;
        wr(10'(t), 32'(v));
    endtask

    function automatic int exp_win(int t);
        int best = 0; int w = 0;
        for (int n = 1; n <= NS; n++)
            if (m_en[n] && (irq_src[n] || m_sw[n]) && m_tgt[n] == t[0] &&
                m_prio[n] > m_mask[t] && m_prio[n] > best) begin
                best = m_prio[n]; w = n;
            end
        return w;
    endfunction

    function automatic logic [31:0] exp_pend();
        logic [31:0] r = '0;
        for (int n = 1; n <= NS; n++) r[n] = irq_src[n] | m_sw[n];
        return r;
    endfunction

    task automatic check_targets(string req);
        logic [31:0] d;
        int w;
        @(posedge clk); @(negedge clk);
        for (int t = 0; t < 2; t++) begin
            w = exp_win(t);
            rd(10'h040 + 10'(t), d);
            chk(req, d, {m_base[t], 3'b000, 5'(w), 3'b000});
        end
        chk(req, {31'd0, irq_norm}, {31'd0, exp_win(0) != 0});
        chk(req, {31'd0, irq_fast}, {31'd0, exp_win(1) != 0});
    endtask

    task automatic step_lfsr();
        for (int k = 0; k < 7; k++)
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int n = 1; n <= NS; n++) begin
            m_prio[n] = 0; m_tgt[n] = 0; m_en[n] = 0; m_sw[n] = 0;
        end
        m_mask[0] = 0; m_mask[1] = 0; m_base[0] = '0; m_base[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        chk("R1 irq_norm", {31'd0, irq_norm}, 32'd0);
        chk("R1 irq_fast", {31'd0, irq_fast}, 32'd0);
        rd(10'h000, d); chk("R1 mask0", d, 32'd0);
        rd(10'h001, d); chk("R1 mask1", d, 32'd0);
        rd(10'h040, d); chk("R1 vec0", d, 32'd0);
        rd(10'h041, d); chk("R1 vec1", d, 32'd0);
        rd(10'h080, d); chk("R1 pending", d, 32'd0);
        for (int n = 1; n <= NS; n++) begin
            rd(10'h100 + 10'(n), d); chk("R1 req", d, 32'd0);
        end

        // R3: features word
        rd(10'h0C0, d); chk("R3 features", d, 32'h0002_101D);

        // R6: threshold keeps only 4 bits
        wr(10'h000, 32'hFFFF_FFFA); rd(10'h000, d); chk("R6 mask0 width", d, 32'h0000_000A);
        wr(10'h001, 32'h1234_5673); rd(10'h001, d); chk("R6 mask1 width", d, 32'h0000_0003);
        set_mask(0, 0); set_mask(1, 0);

        // R4: request register layout, bit 31 and junk bits ignored on write
        for (int n = 1; n <= NS; n++) begin
            int p = n % 16; bit t = n[0]; bit e = (n % 3) != 0;
            m_prio[n] = p; m_tgt[n] = t; m_en[n] = e; m_sw[n] = 0;
            wr(10'h100 + 10'(n), 32'h80FC_E6F0 | 32'(p) | (32'(t) << 8) | (32'(e) << 16));
            rd(10'h100 + 10'(n), d);
            chk("R4 readback", d, 32'(p) | (32'(t) << 8) | (32'(e) << 16));
        end
        for (int n = 1; n <= NS; n++) set_req(n, 0, 0, 0, 0);

        // R2/R4: walking input, pending word and bit 31
        for (int n = 1; n <= NS; n++) begin
            @(negedge clk); irq_src = '0; irq_src[n] = 1'b1;
            rd(10'h080, d); chk("R2 pending walk", d, 32'(1) << n);
            rd(10'h100 + 10'(n), d); chk("R4 raw pending bit31", d, 32'h8000_0000);
        end
        @(negedge clk); irq_src = '0;
        set_req(4, 0, 0, 0, 1); set_req(29, 0, 1, 0, 1); set_req(1, 0, 0, 0, 1);
        rd(10'h080, d); chk("R2 software request", d, exp_pend());
        irq_src = 29'h1555_5555;
        rd(10'h080, d); chk("R2 input or software", d, exp_pend());
        chk("R2 edge bits zero", d & 32'hC000_0001, 32'd0);
        irq_src = '0;
        set_req(4, 0, 0, 0, 0); set_req(29, 0, 0, 0, 0); set_req(1, 0, 0, 0, 0);

        // R8: base fields
        wr(10'h040, 32'hFFFF_FFFF); m_base[0] = 21'h1F_FFFF;
        wr(10'h041, 32'h1234_5FFF); m_base[1] = 21'h02_468B;
        check_targets("R8 base idle");

        // R5 R7 R8 R9 R10: mixed sweep with LFSR inputs and threshold sweep
        for (int n = 1; n <= NS; n++) set_req(n, (n * 5 + 3) % 16, (n % 3) == 1, (n % 7) != 0, 0);
        for (int it = 0; it < 48; it++) begin
            step_lfsr();
            @(negedge clk); irq_src = lfsr[29:1];
            set_mask(0, it % 16); set_mask(1, (it * 3 + 5) % 16);
            check_targets("R5 R7 R10 sweep");
        end

        // R7: all equal priority, lowest number wins
        for (int n = 1; n <= NS; n++) set_req(n, 9, 0, 1, 0);
        set_mask(0, 8); set_mask(1, 0);
        for (int it = 0; it < 24; it++) begin
            step_lfsr();
            @(negedge clk); irq_src = lfsr[29:1];
            check_targets("R7 tie lowest");
        end

        // R5: disabled source and priority 0 never win
        @(negedge clk); irq_src = '0;
        for (int n = 1; n <= NS; n++) set_req(n, 0, 0, 0, 0);
        set_mask(0, 0);
        set_req(1, 15, 0, 0, 0); set_req(2, 0, 0, 1, 0);
        @(negedge clk); irq_src[1] = 1'b1; irq_src[2] = 1'b1;
        check_targets("R5 disabled or prio0");
        set_req(3, 1, 0, 1, 1);
        check_targets("R5 software request eligible");
        set_mask(0, 1);
        check_targets("R5 equal to mask blocked");
        set_req(3, 0, 0, 0, 0);

        // R9: output lags by one edge
        set_mask(0, 0); set_req(5, 3, 0, 1, 0);
        @(negedge clk); irq_src = '0;
        @(posedge clk); @(negedge clk);
        irq_src[5] = 1'b1;
        #1 chk("R9 not yet", {31'd0, irq_norm}, 32'd0);
        @(posedge clk); #1 chk("R9 after edge", {31'd0, irq_norm}, 32'd1);
        @(negedge clk); irq_src[5] = 1'b0;
        #1 chk("R9 holds until edge", {31'd0, irq_norm}, 32'd1);
        @(posedge clk); #1 chk("R9 drops after edge", {31'd0, irq_norm}, 32'd0);

        // R6: full threshold blocks the fast target
        for (int n = 1; n <= NS; n++) set_req(n, 15, 1, 1, 1);
        set_mask(1, 15);
        check_targets("R6 full mask");
        set_mask(1, 14);
        check_targets("R6 mask 14 lets 15");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule